// File: doc/BRIEF.md
# LIN Frame Receive Buffer

This block gathers the data bytes of a single LIN frame from an upstream byte receiver, which presents each byte together with a one-cycle valid strobe. It packs up to eight bytes into two 32-bit words that software can read. It can also treat one extra byte after the data as a checksum and compare it against the classic LIN checksum. A receive-ready flag rises only once the whole frame has arrived. The read that clears this flag is the read of the data word that holds the frame's last byte.

Software configures the frame length, the compare-checksum bit and the request enable through a small register write port. It reads the data words, the control register and a status register through a read port that has one cycle of latency. A frame-start pulse from the upstream logic throws away any partial frame. The block only raises a request output. Interrupt and DMA routing sit outside it.

Top module: `lin_frame_rxbuf`

## Requirements
- R1: The ready flag (status bit 0, address 3) sets only after the programmed number of data bytes has arrived. That number is the control field bits [2:0] plus one. When the compare-checksum bit is set, the checksum byte must also arrive. The flag becomes visible in the status register on the second rising edge after the final byte's valid edge.
- R2: Data byte k is stored at bits [8*(k%4)+7 : 8*(k%4)] of word k/4. Word 0 is read at address 0 and word 1 at address 1. Byte positions that the frame did not fill read as zero.
- R3: With a length of 4 or fewer, a read of address 0 clears the ready flag, and a read of address 1 leaves it set.
- R4: With a length greater than 4, a read of address 1 clears the ready flag, and a read of address 0 leaves it set.
- R5: While the compare-checksum bit (control bit 4) is set, the byte that follows the data bytes is taken as the checksum and is not stored. The expected checksum is the 8-bit sum of the data bytes, with every carry out of bit 7 added back in, then inverted. A mismatch sets the sticky status bit 1. Writing 1 to status bit 1 clears it.
- R6: The compare-checksum bit clears itself once the checksum byte has been received and compared.
- R7: If a frame completes while the ready flag is still set, status bit 2 (overrun) sets and the stored words take the new frame's data. Writing 1 to status bit 2 clears it.
- R8: rx_req_o is high exactly when the ready flag is set and the request enable (control bit 8) is set.
- R9: A frame_start_i pulse discards the bytes collected so far, and the next byte is taken as byte 0.
- R10: rd_data_o presents the addressed register one cycle after rd_en_i and holds it until the next read. The control register reads back its length field, bit 4 and bit 8. Everything is zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Pulse that restarts byte collection |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | byte_i is valid this cycle |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address: 0/1 data words, 2 control, 3 status |
| rd_data_o | output | 32 | Read data, one cycle after the strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 2 control, 3 status (write 1 to clear) |
| wr_data_i | input | 32 | Write data |
| rx_req_o | output | 1 | Receive request |

## Verification
The hardest situation to reach is a checksum byte whose value depends on an end-around carry. The stimulus reaches it with a frame of two 0xFF data bytes, whose sum wraps to 0xFF and gives an expected checksum of 0x00. A second hard case is a completed frame landing on a ready flag that software has not yet cleared. The bench sends two one-byte frames back to back without reading between them, then checks that the overrun flag is set and that the second byte is what remains. Dropping a partial frame is driven by pulsing frame_start_i after two bytes of a four-byte frame.

// File: rtl/lin_rxbuf_pkg.sv
package lin_rxbuf_pkg;
  localparam int CTRL_CC_BIT  = 4;
  localparam int CTRL_EN_BIT  = 8;
  localparam int STAT_RDY_BIT = 0;
  localparam int STAT_ERR_BIT = 1;
  localparam int STAT_OVR_BIT = 2;
  localparam int BYTE_W       = 8;
  localparam int BYTES_PER_WORD = 4;

  // end-around-carry byte addition
  function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, acc} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction
endpackage

// File: rtl/lin_rxbuf_collect.sv
module lin_rxbuf_collect
  import lin_rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_start_i,
  input  logic [7:0]                    byte_i,
  input  logic                          byte_vld_i,
  input  logic [LEN_W-1:0]              nbytes_m1_i,
  input  logic                          cc_i,
  output logic [MAX_BYTES*BYTE_W-1:0]   staged_o,
  output logic                          done_o,
  output logic                          mism_o,
  output logic                          chk_done_o
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sum_q;
  logic [7:0]       stage_q [MAX_BYTES];
  logic             done_q, mism_q, chkd_q;

  logic [CNT_W-1:0] last_idx;
  logic             in_data, take_data, take_chk, hit_last;

  always_comb begin
    last_idx  = CNT_W'(nbytes_m1_i);
    in_data   = (cnt_q <= last_idx);
    take_data = byte_vld_i && !frame_start_i && in_data;
    take_chk  = byte_vld_i && !frame_start_i && !in_data && cc_i;
    hit_last  = take_data && (cnt_q == last_idx) && !cc_i;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start_i) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (hit_last || take_chk) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take_data) begin
      cnt_q <= cnt_q + 1'b1;
      sum_q <= csum_add(sum_q, byte_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      mism_q <= 1'b0;
      chkd_q <= 1'b0;
    end else begin
      done_q <= hit_last || take_chk;
      mism_q <= take_chk && (byte_i != ~sum_q);
      chkd_q <= take_chk;
    end
  end

  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || frame_start_i)
        stage_q[i] <= '0;
      else if (take_data && (cnt_q == CNT_W'(i)))
        stage_q[i] <= byte_i;
      else if (done_q)
        stage_q[i] <= '0;
    end
    assign staged_o[i*BYTE_W +: BYTE_W] = stage_q[i];
  end

  assign done_o     = done_q;
  assign mism_o     = mism_q;
  assign chk_done_o = chkd_q;
endmodule

// File: rtl/lin_rxbuf_regs.sv
module lin_rxbuf_regs
  import lin_rxbuf_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 3,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [MAX_BYTES*BYTE_W-1:0] staged_i,
  input  logic                        done_i,
  input  logic                        mism_i,
  input  logic                        chk_done_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [31:0]                 wr_data_i,
  output logic [LEN_W-1:0]            nbytes_m1_o,
  output logic                        cc_o,
  output logic [31:0]                 rd_data_o,
  output logic                        ready_o,
  output logic                        rx_req_o
);
  localparam int WORD_W = BYTES_PER_WORD * BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_WORDS + 1);
  localparam int PAD_W = NUM_WORDS * WORD_W;

  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [LEN_W-1:0]  len_q;
  logic              cc_q, en_q, ready_q, err_q, ovr_q, req_q;
  logic [31:0]       rd_q;

  logic [PAD_W-1:0]  staged_pad;
  logic              wr_ctrl, wr_stat, rd_clr;
  logic              ready_d, en_d;
  logic [ADDR_W-1:0] clr_addr;
  logic [31:0]       rd_mux, ctrl_view, stat_view;

  assign staged_pad = PAD_W'(staged_i);

  always_comb begin
    wr_ctrl  = wr_en_i && (wr_addr_i == CTRL_ADDR);
    wr_stat  = wr_en_i && (wr_addr_i == STAT_ADDR);
    clr_addr = ADDR_W'(len_q >> 2);
    rd_clr   = rd_en_i && (rd_addr_i == clr_addr);
    ready_d  = done_i ? 1'b1 : (rd_clr ? 1'b0 : ready_q);
    en_d     = wr_ctrl ? wr_data_i[CTRL_EN_BIT] : en_q;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[LEN_W-1:0]   = len_q;
    ctrl_view[CTRL_CC_BIT] = cc_q;
    ctrl_view[CTRL_EN_BIT] = en_q;
    stat_view = '0;
    stat_view[STAT_RDY_BIT] = ready_q;
    stat_view[STAT_ERR_BIT] = err_q;
    stat_view[STAT_OVR_BIT] = ovr_q;
    rd_mux = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_mux = 32'(words_q[i]);
    if (rd_addr_i == CTRL_ADDR) rd_mux = ctrl_view;
    if (rd_addr_i == STAT_ADDR) rd_mux = stat_view;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)         words_q[w] <= '0;
      else if (done_i) words_q[w] <= staged_pad[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cc_q  <= 1'b0;
      en_q  <= 1'b0;
    end else if (wr_ctrl) begin
      len_q <= wr_data_i[LEN_W-1:0];
      cc_q  <= wr_data_i[CTRL_CC_BIT];
      en_q  <= wr_data_i[CTRL_EN_BIT];
    end else if (chk_done_i) begin
      cc_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
      req_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      ready_q <= ready_d;
      req_q   <= ready_d && en_d;
      if (done_i && mism_i)                      err_q <= 1'b1;
      else if (wr_stat && wr_data_i[STAT_ERR_BIT]) err_q <= 1'b0;
      if (done_i && ready_q)                     ovr_q <= 1'b1;
      else if (wr_stat && wr_data_i[STAT_OVR_BIT]) ovr_q <= 1'b0;
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign nbytes_m1_o = len_q;
  assign cc_o        = cc_q;
  assign rd_data_o   = rd_q;
  assign ready_o     = ready_q;
  assign rx_req_o    = req_q;
endmodule

// File: rtl/lin_frame_rxbuf.sv
module lin_frame_rxbuf
  import lin_rxbuf_pkg::*;
#(
  parameter  int MAX_BYTES = 8,
  localparam int LEN_W     = $clog2(MAX_BYTES),
  localparam int NUM_WORDS = (MAX_BYTES + BYTES_PER_WORD - 1) / BYTES_PER_WORD,
  localparam int ADDR_W    = $clog2(NUM_WORDS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              rx_req_o
);
  logic [MAX_BYTES*BYTE_W-1:0] staged_w;
  logic                        done_w, mism_w, chkd_w, cc_w, ready_w;
  logic [LEN_W-1:0]            len_w;

  lin_rxbuf_collect #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) collect_i (
    .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
    .byte_i(byte_i), .byte_vld_i(byte_vld_i),
    .nbytes_m1_i(len_w), .cc_i(cc_w),
    .staged_o(staged_w), .done_o(done_w), .mism_o(mism_w), .chk_done_o(chkd_w)
  );

  lin_rxbuf_regs #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W),
                   .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .staged_i(staged_w), .done_i(done_w),
    .mism_i(mism_w), .chk_done_i(chkd_w),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .nbytes_m1_o(len_w), .cc_o(cc_w), .rd_data_o(rd_data_o),
    .ready_o(ready_w), .rx_req_o(rx_req_o)
  );
endmodule

// File: rtl/lin_rxbuf_chk.sv
module lin_rxbuf_chk #(
  parameter int ADDR_W    = 2,
  parameter int NUM_WORDS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              done_w,
  input logic              mism_w,
  input logic              chkd_w,
  input logic              cc_w,
  input logic              ready_w,
  input logic              rx_req_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i
);
  // R8
  req_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rx_req_o |-> ready_w);

  // R1
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_w) |-> $past(done_w));

  // R7
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done_w |=> ready_w);

  // R5
  mism_needs_chk_chk: assert property (@(posedge clk) disable iff (rst)
    mism_w |-> chkd_w);

  // R6
  cc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (chkd_w && !(wr_en_i && wr_addr_i == ADDR_W'(NUM_WORDS))) |=> !cc_w);
endmodule

bind lin_frame_rxbuf lin_rxbuf_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) chk_i (
  .clk(clk), .rst(rst), .done_w(done_w), .mism_w(mism_w), .chkd_w(chkd_w),
  .cc_w(cc_w), .ready_w(ready_w), .rx_req_o(rx_req_o),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i)
);

// File: tb/lin_frame_rxbuf_tb.sv
module lin_frame_rxbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        byte_vld = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rx_req;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  lin_frame_rxbuf dut_i (
    .clk(clk), .rst(rst), .frame_start_i(frame_start), .byte_i(byte_d),
    .byte_vld_i(byte_vld), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rx_req_o(rx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned q[$];
  int          m_len;
  bit          m_cc, m_en, m_ready, m_err, m_ovr, m_req;
  logic [31:0] m_w0, m_w1, m_rd;
  bit          pd, pd_mis, pd_chk;
  logic [31:0] pd_w0, pd_w1;

  function automatic logic [63:0] pack_q();
    logic [63:0] v = '0;
    for (int k = 0; k < q.size(); k++) v[8*k +: 8] = q[k];
    return v;
  endfunction

  function automatic logic [7:0] ref_csum();
    int s = 0;
    for (int k = 0; k < q.size(); k++) begin
      s = s + q[k];
      if (s > 255) s = s - 255;
    end
    return ~(8'(s));
  endfunction

  always @(posedge clk) begin
    bit          n_pd, n_mis, n_chk, clr;
    logic [63:0] pk;
    logic [31:0] stat;
    if (rst) begin
      q.delete();
      m_len = 0; m_cc = 0; m_en = 0; m_ready = 0; m_err = 0; m_ovr = 0; m_req = 0;
      m_w0 = 0; m_w1 = 0; m_rd = 0; pd = 0; pd_mis = 0; pd_chk = 0; pd_w0 = 0; pd_w1 = 0;
    end else begin
      n_pd = 0; n_mis = 0; n_chk = 0; pk = '0;
      if (frame_start) q.delete();
      else if (byte_vld) begin
        if (q.size() < m_len + 1) begin
          q.push_back(byte_d);
          if (q.size() == m_len + 1 && !m_cc) begin
            n_pd = 1; pk = pack_q(); q.delete();
          end
        end else if (m_cc) begin
          n_pd = 1; n_chk = 1; n_mis = (byte_d != ref_csum()); pk = pack_q(); q.delete();
        end
      end
      if (rd_en) begin
        stat = {29'd0, m_ovr, m_err, m_ready};
        case (rd_addr)
          2'd0: m_rd = m_w0;
          2'd1: m_rd = m_w1;
          2'd2: m_rd = {23'd0, m_en, 3'd0, m_cc, 1'b0, 3'(m_len)};
          default: m_rd = stat;
        endcase
      end
      clr = rd_en && (rd_addr == ((m_len > 3) ? 2'd1 : 2'd0));
      if (pd && pd_mis) m_err = 1;
      else if (wr_en && wr_addr == 2'd3 && wr_data[1]) m_err = 0;
      if (pd && m_ready) m_ovr = 1;
      else if (wr_en && wr_addr == 2'd3 && wr_data[2]) m_ovr = 0;
      if (pd) begin m_w0 = pd_w0; m_w1 = pd_w1; m_ready = 1; end
      else if (clr) m_ready = 0;
      if (wr_en && wr_addr == 2'd2) begin
        m_len = int'(wr_data[2:0]); m_cc = wr_data[4]; m_en = wr_data[8];
      end else if (pd && pd_chk) m_cc = 0;
      m_req = m_ready && m_en;
      pd = n_pd; pd_mis = n_mis; pd_chk = n_chk; pd_w0 = pk[31:0]; pd_w1 = pk[63:32];
    end
  end

  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R8 rx_req vs model", {31'd0, rx_req}, {31'd0, m_req});
      chk("R10 rd_data vs model", rd_data, m_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_d = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd(2'd3, v); chk("R10 status after reset", v, 32'h0);
    rd(2'd2, v); chk("R10 ctrl after reset", v, 32'h0);
    chk("R8 req after reset", {31'd0, rx_req}, 32'h0);

    // R1/R2/R3: three-byte frame
    wr(2'd2, 32'h2);
    rd(2'd2, v); chk("R10 ctrl readback", v, 32'h2);
    send(8'h11); send(8'h22); settle();
    rd(2'd3, v); chk("R1 not ready mid-frame", v, 32'h0);
    send(8'h33); settle();
    rd(2'd3, v); chk("R1 ready after last byte", v, 32'h1);
    rd(2'd1, v); chk("R2 unfilled word reads zero", v, 32'h0);
    rd(2'd3, v); chk("R3 upper read keeps ready", v, 32'h1);
    rd(2'd0, v); chk("R2 lower word packing", v, 32'h00332211);
    rd(2'd3, v); chk("R3 lower read clears ready", v, 32'h0);

    // R4: eight-byte frame
    wr(2'd2, 32'h7);
    for (int k = 1; k <= 8; k++) send(8'(k));
    settle();
    rd(2'd0, v); chk("R2 word0 of 8", v, 32'h04030201);
    rd(2'd3, v); chk("R4 lower read keeps ready", v, 32'h1);
    rd(2'd1, v); chk("R2 word1 of 8", v, 32'h08070605);
    rd(2'd3, v); chk("R4 upper read clears ready", v, 32'h0);

    // R5/R6: good checksum
    wr(2'd2, 32'h11);
    send(8'hA0); send(8'h05); settle();
    rd(2'd3, v); chk("R1 waits for checksum byte", v, 32'h0);
    send(8'h5A); settle();
    rd(2'd3, v); chk("R5 good checksum no error", v, 32'h1);
    rd(2'd2, v); chk("R6 cc bit cleared itself", v, 32'h1);
    rd(2'd0, v); chk("R5 checksum not stored", v, 32'h000005A0);

    // R5: end-around carry, checksum 0x00 is correct
    wr(2'd2, 32'h11);
    send(8'hFF); send(8'hFF); send(8'h00); settle();
    rd(2'd3, v); chk("R5 carry wrap checksum ok", v, 32'h1);
    rd(2'd0, v); chk("R2 carry frame data", v, 32'h0000FFFF);

    // R5: bad checksum and write-1-to-clear
    wr(2'd2, 32'h11);
    send(8'h10); send(8'h20); send(8'h00); settle();
    rd(2'd3, v); chk("R5 mismatch sets error", v, 32'h3);
    wr(2'd3, 32'h2);
    rd(2'd3, v); chk("R5 error cleared by write 1", v, 32'h1);
    rd(2'd0, v);

    // R7: overrun
    wr(2'd2, 32'h0);
    send(8'h77); settle();
    send(8'h88); settle();
    rd(2'd3, v); chk("R7 overrun set", v, 32'h5);
    rd(2'd0, v); chk("R7 data overwritten", v, 32'h00000088);
    wr(2'd3, 32'h4);
    rd(2'd3, v); chk("R7 overrun cleared", v, 32'h0);

    // R8: request output
    wr(2'd2, 32'h100);
    send(8'h42); settle();
    chk("R8 req with enable and ready", {31'd0, rx_req}, 32'h1);
    rd(2'd0, v); settle();
    chk("R8 req drops with ready", {31'd0, rx_req}, 32'h0);
    send(8'h43); settle();
    wr(2'd2, 32'h0); settle();
    chk("R8 req off when disabled", {31'd0, rx_req}, 32'h0);
    rd(2'd3, v); chk("R8 ready stays while disabled", v, 32'h1);
    rd(2'd0, v);

    // R9: frame restart
    wr(2'd2, 32'h3);
    send(8'h01); send(8'h02); restart();
    send(8'h09); send(8'h08); send(8'h07); settle();
    rd(2'd3, v); chk("R9 restart discards partial", v, 32'h0);
    send(8'h06); settle();
    rd(2'd0, v); chk("R9 data after restart", v, 32'h06070809);

    settle();
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule